// File: doc/BRIEF.md
# Stream Link Fill-Event Interrupt Generator

This block turns the per-link FIFO fill flags of a multi-link streaming peripheral into one interrupt request line for the CPU. Each link supplies a half-full flag and a data-available flag. When any flag rises while the global enable is set, the block emits a one-cycle interrupt pulse. The pulse carries no link identity. The handler finds the links that need service by reading the status flags. It can then service them before it issues accesses that would otherwise stall.

After a pulse, the interrupt stays outstanding until the CPU reads the status register. The bus logic reports that read to this block as a one-cycle strobe, and the read is the acknowledge. Flag edges that arrive while an interrupt is outstanding are not lost. They are held in a single pending bit, and that bit raises one new pulse once the acknowledge has been taken. Clearing the enable drops the outstanding interrupt and any pending event.

Top module: `slk_irq_gen`

## Requirements
- R1: While reset is asserted and after reset is released, `irq` is 0 until an event occurs.
- R2: With `enable` = 1 and no interrupt outstanding, a 0-to-1 change of any bit of `half_flags` or `avail_flags` gives `irq` = 1 for exactly one cycle, starting at the first clock edge that samples the new flag value.
- R3: A flag that stays at 1 raises no further interrupt once the interrupt it caused has been acknowledged.
- R4: While `enable` = 0, `irq` stays 0 whatever the flags do.
- R5: After an interrupt pulse, no further pulse occurs until `status_rd` = 1 has been sampled.
- R6: A flag rise that arrives while an interrupt is outstanding is buffered. After the acknowledging `status_rd`, `irq` pulses at the second clock edge following that read, and not before.
- R7: Any number of flag rises during one outstanding interrupt produce exactly one further pulse.
- R8: `status_rd` sampled while no interrupt is outstanding has no effect: it raises no pulse and does not suppress the next event.
- R9: Setting `enable` to 0 discards both the outstanding interrupt and any buffered event. After re-enabling, there is no pulse without a new flag rise, and a new rise fires without any status read.
- R10: Flag edges are tracked even while disabled, so a flag that is already 1 when `enable` is set does not fire.
- R11: A 1-to-0 change of a flag never raises an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Global peripheral enable |
| half_flags | input | NUM_LINKS | Per-link FIFO half-full flags |
| avail_flags | input | NUM_LINKS | Per-link FIFO data-available flags |
| status_rd | input | 1 | One-cycle strobe for a status register read (acknowledge) |
| irq | output | 1 | Interrupt request pulse |

## Verification
Single rises on one link are driven against held flags, so a true edge can be told apart from a level. Bursts of rises on different links and flag types are driven while an interrupt is outstanding; they show that the events are buffered and merged into one re-raise, and the exact cycle of that re-raise is checked. Status reads with nothing outstanding, falling flags, and flags that change while the block is disabled are also driven. These separate a true acknowledge from a stray read, and a cleared state from a stale pending event.

// File: rtl/slk_irq_pkg.sv
package slk_irq_pkg;
  typedef enum logic {
    ACK_IDLE = 1'b0,
    ACK_WAIT = 1'b1
  } ack_state_e;
endpackage

// File: rtl/slk_irq_edge.sv
module slk_irq_edge #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  // history follows the flags every cycle, enabled or not
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_comb prev_d[g] = cond_i[g];
    assign rise_o[g] = cond_i[g] & ~prev_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= prev_d[g];
    end
  end

  // R11
  no_fall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == '0) |-> (rise_o == '0));
endmodule

// File: rtl/slk_irq_ctrl.sv
module slk_irq_ctrl
  import slk_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic event_i,
  input  logic ack_i,
  output logic irq_o
);
  ack_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       irq_q, irq_d;
  logic       fire;
  logic       state_ce, pend_ce;

  always_comb begin
    fire    = en_i && (state_q == ACK_IDLE) && (pend_q || event_i);
    state_d = state_q;
    pend_d  = pend_q;
    irq_d   = fire;
    if (!en_i) begin
      state_d = ACK_IDLE;
      pend_d  = 1'b0;
    end else if (fire) begin
      state_d = ACK_WAIT;
      pend_d  = 1'b0;
    end else if (state_q == ACK_WAIT) begin
      if (event_i) pend_d = 1'b1;
      if (ack_i)   state_d = ACK_IDLE;
    end
    state_ce = (state_d != state_q);
    pend_ce  = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (state_ce) state_q <= state_d;
      if (pend_ce)  pend_q  <= pend_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R2
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R4
  irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !irq_q);
  // R5
  no_refire_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ACK_WAIT && !ack_i) |=> !irq_q);
  // R6
  pending_reraise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && state_q == ACK_WAIT && ack_i && en_i) ##1 en_i |=> irq_q);
endmodule

// File: rtl/slk_irq_gen.sv
module slk_irq_gen #(
  parameter int NUM_LINKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [NUM_LINKS-1:0] half_flags,
  input  logic [NUM_LINKS-1:0] avail_flags,
  input  logic                 status_rd,
  output logic                 irq
);
  localparam int COND_W = 2 * NUM_LINKS;

  logic [COND_W-1:0] cond_all;
  logic [COND_W-1:0] rise_all;
  logic              any_event;

  assign cond_all  = {half_flags, avail_flags};
  assign any_event = |rise_all;

  slk_irq_edge #(.WIDTH(COND_W)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_i (cond_all),
    .rise_o (rise_all)
  );

  slk_irq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (enable),
    .event_i (any_event),
    .ack_i   (status_rd),
    .irq_o   (irq)
  );
endmodule

// File: tb/slk_irq_gen_tb.sv
module slk_irq_gen_tb;
  localparam int CLK_P = 10;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic enable;
  logic [NL-1:0] half_flags, avail_flags;
  logic status_rd;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { bit exp; string req; } item_t;
  item_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  slk_irq_gen #(.NUM_LINKS(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .half_flags(half_flags), .avail_flags(avail_flags),
    .status_rd(status_rd), .irq(irq)
  );

  // monitor: compares irq a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (irq !== it.exp) begin
        bad++;
        $display("FAIL %s: irq actual=%b expected=%b at %0t", it.req, irq, it.exp, $time);
      end
    end
  end

  // driver: applies one cycle of stimulus at the falling edge and queues the expected irq
  task automatic step(input bit en, input logic [NL-1:0] h, input logic [NL-1:0] a,
                      input bit rd, input bit exp, input string req);
    item_t it;
    enable = en; half_flags = h; avail_flags = a; status_rd = rd;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; half_flags = '0; avail_flags = '0; status_rd = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (irq !== 1'b0) begin bad++; $display("FAIL R1: irq actual=%b expected=0 in reset", irq); end
    rst_n = 1'b1;
    step(1, 4'b0000, 4'b0000, 0, 0, "R1");
    step(1, 4'b0000, 4'b0000, 0, 0, "R1");
    // R2: single rise fires a one-cycle pulse
    step(1, 4'b0000, 4'b0001, 0, 1, "R2");
    step(1, 4'b0000, 4'b0001, 0, 0, "R2");
    // acknowledge, then the held flag must stay quiet (R3)
    step(1, 4'b0000, 4'b0001, 1, 0, "R5");
    step(1, 4'b0000, 4'b0001, 0, 0, "R3");
    step(1, 4'b0000, 4'b0001, 0, 0, "R3");
    // R11: falling flag
    step(1, 4'b0000, 4'b0000, 0, 0, "R11");
    // R8: stray read while idle, then a normal event
    step(1, 4'b0000, 4'b0000, 1, 0, "R8");
    step(1, 4'b0010, 4'b0000, 0, 1, "R8");
    // R5/R7: several rises while outstanding
    step(1, 4'b0010, 4'b0100, 0, 0, "R5");
    step(1, 4'b0000, 4'b0000, 0, 0, "R5");
    step(1, 4'b1000, 4'b0000, 0, 0, "R7");
    step(1, 4'b1000, 4'b0000, 0, 0, "R5");
    // R6: acknowledge, re-raise at the second edge after the read
    step(1, 4'b1000, 4'b0000, 1, 0, "R6");
    step(1, 4'b1000, 4'b0000, 0, 1, "R6");
    step(1, 4'b1000, 4'b0000, 0, 0, "R6");
    step(1, 4'b1000, 4'b0000, 0, 0, "R7");
    step(1, 4'b1000, 4'b0000, 1, 0, "R7");
    step(1, 4'b1000, 4'b0000, 0, 0, "R7");
    step(1, 4'b1000, 4'b0000, 0, 0, "R7");
    // R9: disable clears outstanding and pending state
    step(1, 4'b1000, 4'b0001, 0, 1, "R9");
    step(1, 4'b1000, 4'b0011, 0, 0, "R9");
    step(0, 4'b1000, 4'b0011, 0, 0, "R4");
    step(0, 4'b1000, 4'b0111, 0, 0, "R4");
    step(1, 4'b1000, 4'b0111, 0, 0, "R9");
    step(1, 4'b1000, 4'b0111, 0, 0, "R9");
    step(1, 4'b1000, 4'b1111, 0, 1, "R9");
    step(1, 4'b1000, 4'b1111, 1, 0, "R9");
    // R10: flag rising while disabled, then enable
    step(0, 4'b0000, 4'b0000, 0, 0, "R4");
    step(0, 4'b0001, 4'b0000, 0, 0, "R4");
    step(1, 4'b0001, 4'b0000, 0, 0, "R10");
    step(1, 4'b0001, 4'b0000, 0, 0, "R10");
    // R11: everything falls while enabled
    step(1, 4'b0000, 4'b0000, 0, 0, "R11");
    step(1, 4'b0000, 4'b0000, 0, 0, "R11");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule